// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block takes a floating-point operand that has already been unpacked into a class code, a sign, an unbiased exponent and a normalised mantissa, and turns it into a two's-complement integer of `OUT_W` bits (32 by default). It always truncates toward zero and never looks at a rounding mode. Two flags come with each result. Inexact is raised when fraction bits were discarded. Invalid is raised when the operand cannot be represented.

The operand is captured on a clock edge when `in_valid` is high, and the result appears one cycle later with `out_valid`. A two-state controller tracks this. `ST_EMPTY` means no result is presented. `ST_FULL` means a result is presented on this cycle. The transition `ACCEPT` (any state to `ST_FULL`) is taken whenever `in_valid` is high. The transition `DRAIN` (any state to `ST_EMPTY`) is taken whenever `in_valid` is low. Reset enters `ST_EMPTY`.

For a number-class operand, the mantissa has its leading one at bit `MANT_W-1` and represents `mant * 2^(exp-(MANT_W-1))`. It is shifted right until the integer part sits in the low bits. Every bit shifted out feeds a sticky bit that becomes the inexact flag.

Top module: `fti_convert`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_int`, `out_inexact` and `out_invalid` are all zero.
- R2: A result is presented with `out_valid` high exactly one cycle after an operand is accepted with `in_valid` high. With `in_valid` low, `out_valid` is low on the next cycle.
- R3: Class code 0 (zero) gives result 0 with both flags low, whatever the sign, exponent and mantissa are.
- R4: Class codes 2 (infinity) and 3 (NaN) give the saturated value: 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1. Invalid is high and inexact is low.
- R5: For class code 1 (number), an exponent of 32 or more gives the saturated value of R4 with invalid high and inexact low.
- R6: A number whose value is an integer in range gives that integer exactly, with both flags low.
- R7: A number with a nonzero fraction gives its integer part truncated toward zero, for both signs, with inexact high and invalid low.
- R8: A number with a negative exponent gives 0 with inexact high.
- R9: A magnitude of 2^31 or more overflows for sign 0. For sign 1 the overflow threshold is above 2^31, so -2^31 (exact or with a fraction below one) gives 0x80000000 without invalid.
- R10: A valid negative result is the two's-complement negation of the truncated magnitude.
- R11: A right shift of `MANT_W` places or more leaves a magnitude of 0, with inexact set when the mantissa is nonzero.
- R12: Invalid and inexact are never high together. The result and flags hold their values on cycles without a new operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one at bit MANT_W-1 |
| out_valid | output | 1 | Result presented |
| out_int | output | OUT_W | Two's-complement integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Operand not representable, result saturated |

## Verification
The hardest cases to reach are the ones right at the overflow boundary. Random mantissas almost never land on a magnitude of exactly 2^31, or on 2^31 plus a small fraction, and those are the cases where the two signs must behave differently. Directed vectors therefore build these operands bit by bit, with exponent 31 and mantissas that are a lone leading one or a leading one with a single low fraction bit, and present them with both signs. The random phase spreads exponents from far below zero to beyond 32, so that both the deep-shift path and the overflow path are exercised often.

// File: rtl/fti_pkg.sv
package fti_pkg;

    typedef enum logic [1:0] {
        FCLS_ZERO = 2'd0,
        FCLS_NUM  = 2'd1,
        FCLS_INF  = 2'd2,
        FCLS_NAN  = 2'd3
    } fcls_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } fsm_e;

endpackage

// File: rtl/fti_align.sv
// Right shift of the mantissa so that the integer part lands in the low
// OUT_W bits; all bits dropped on the way are collected into a sticky bit.
module fti_align #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 10,
    parameter int OUT_W  = 32
) (
    input  logic [MANT_W-1:0]       mant,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [OUT_W-1:0]        mag,
    output logic                    sticky
);
    localparam int SH_W = EXP_W + $clog2(MANT_W) + 2;
    localparam logic signed [SH_W-1:0] TOP_POS = SH_W'(MANT_W - 1);
    localparam logic signed [SH_W-1:0] SH_LIM  = SH_W'(MANT_W);

    logic signed [SH_W-1:0] sh_s;
    logic [SH_W-1:0]        sh_u;
    logic [MANT_W-1:0]      shifted;
    logic [MANT_W-1:0]      lost;

    assign sh_s = TOP_POS - $signed({{(SH_W-EXP_W){exp_in[EXP_W-1]}}, exp_in});
    assign sh_u = sh_s;

    always_comb begin
        shifted = '0;
        lost    = '0;
        if (sh_s < 0) begin
            // exponent beyond the mantissa; overflow is decided elsewhere
            shifted = mant;
        end else if (sh_s >= SH_LIM) begin
            lost = mant;
        end else begin
            shifted = mant >> sh_u;
            lost    = mant & ~({MANT_W{1'b1}} << sh_u);
        end
    end

    assign mag    = shifted[OUT_W-1:0];
    assign sticky = |lost;

endmodule

// File: rtl/fti_resolve.sv
// Chooses between zero, truncated value and saturation, and sets flags.
module fti_resolve #(
    parameter int EXP_W = 10,
    parameter int OUT_W = 32
) (
    input  fti_pkg::fcls_e          cls,
    input  logic                    sign,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [OUT_W-1:0]        mag,
    input  logic                    sticky,
    output logic [OUT_W-1:0]        res,
    output logic                    nx,
    output logic                    nv
);
    import fti_pkg::*;

    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(OUT_W);

    logic exp_big;
    logic mag_big;
    logic ovf;

    assign exp_big = (exp_in >= EXP_LIM);
    assign mag_big = sign ? (mag > NEG_MIN) : (mag >= NEG_MIN);

    always_comb begin
        unique case (cls)
            FCLS_ZERO: ovf = 1'b0;
            FCLS_NUM:  ovf = exp_big | mag_big;
            FCLS_INF:  ovf = 1'b1;
            FCLS_NAN:  ovf = 1'b1;
        endcase
    end

    always_comb begin
        res = '0;
        nx  = 1'b0;
        nv  = 1'b0;
        if (ovf) begin
            res = sign ? NEG_MIN : POS_MAX;
            nv  = 1'b1;
        end else if (cls == FCLS_NUM) begin
            res = sign ? (~mag + 1'b1) : mag;
            nx  = sticky;
        end
    end

endmodule

// File: rtl/fti_convert.sv
module fti_convert #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 10,
    parameter int OUT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_int,
    output logic                    out_inexact,
    output logic                    out_invalid
);
    import fti_pkg::*;

    fsm_e             state_q;
    fsm_e             state_d;
    fcls_e            cls;
    logic [OUT_W-1:0] mag;
    logic             sticky;
    logic [OUT_W-1:0] res_c;
    logic             nx_c;
    logic             nv_c;

    assign cls = fcls_e'(in_class);

    fti_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_align (
        .mant   (in_mant),
        .exp_in (in_exp),
        .mag    (mag),
        .sticky (sticky)
    );

    fti_resolve #(.EXP_W(EXP_W), .OUT_W(OUT_W)) u_resolve (
        .cls    (cls),
        .sign   (in_sign),
        .exp_in (in_exp),
        .mag    (mag),
        .sticky (sticky),
        .res    (res_c),
        .nx     (nx_c),
        .nv     (nv_c)
    );

    // next-state: ACCEPT into ST_FULL, DRAIN into ST_EMPTY
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_int     <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_int     <= res_c;
            out_inexact <= nx_c;
            out_invalid <= nv_c;
        end
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 10,
    parameter int OUT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [1:0]              in_class,
    input logic                    in_sign,
    input logic signed [EXP_W-1:0] in_exp,
    input logic [MANT_W-1:0]       in_mant,
    input logic                    out_valid,
    input logic [OUT_W-1:0]        out_int,
    input logic                    out_inexact,
    input logic                    out_invalid
);
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(OUT_W);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd0) |=>
            (out_int == '0 && !out_inexact && !out_invalid));

    p_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class[1]) |=>
            (out_invalid && !out_inexact &&
             out_int == ($past(in_sign) ? NEG_MIN : POS_MAX)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd1 && in_exp >= EXP_LIM) |=> out_invalid);

    p_below_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd1 && in_exp < 0 && in_mant != '0) |=>
            (out_int == '0 && out_inexact && !out_invalid));

    p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid && out_int != '0) |->
            (out_int[OUT_W-1] == $past(in_sign)));

    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_inexact && out_invalid));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_int) && $stable(out_inexact) && $stable(out_invalid)));

endmodule

bind fti_convert fti_checker #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_fti_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_sign     (in_sign),
    .in_exp      (in_exp),
    .in_mant     (in_mant),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
);

// File: tb/test_fti_convert.sv
`timescale 1ns/1ps
module test_fti_convert;
    localparam int MANT_W = 40;
    localparam int EXP_W  = 10;
    localparam int OUT_W  = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [1:0]              in_class = 2'd0;
    logic                    in_sign = 1'b0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [MANT_W-1:0]       in_mant = '0;
    logic                    out_valid;
    logic [OUT_W-1:0]        out_int;
    logic                    out_inexact;
    logic                    out_invalid;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fti_convert #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) i_fti_convert (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_class (in_class),
        .in_sign (in_sign), .in_exp (in_exp), .in_mant (in_mant),
        .out_valid (out_valid), .out_int (out_int),
        .out_inexact (out_inexact), .out_invalid (out_invalid)
    );

    // expected {invalid, inexact, value}
    function automatic logic [33:0] ref_conv(logic [1:0] c, logic s, int e, logic [39:0] m);
        longint unsigned mg;
        bit lost;
        int sh;
        logic [31:0] v;
        if (c == 2'd0) return 34'd0;
        if (c[1] || e >= 32) return {2'b10, s ? 32'h8000_0000 : 32'h7FFF_FFFF};
        sh = 39 - e;
        if (sh >= 40) begin
            mg = 0;
            lost = (m != 0);
        end else begin
            mg = longint'(m) >> sh;
            lost = ((mg << sh) != longint'(m));
        end
        if (mg >= 64'h8000_0000 + longint'(s)) return {2'b10, s ? 32'h8000_0000 : 32'h7FFF_FFFF};
        v = mg[31:0];
        if (s) v = -v;
        return {1'b0, lost, v};
    endfunction

    task automatic check(string req, logic [34:0] act, logic [34:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual valid/nv/nx/int=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] c, logic s, int e, logic [39:0] m);
        in_valid = 1'b1;
        in_class = c;
        in_sign  = s;
        in_exp   = EXP_W'(e);
        in_mant  = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic vec(string req, logic [1:0] c, logic s, int e, logic [39:0] m,
                       logic [33:0] exp);
        drive(c, s, e, m);
        check(req, {out_valid, out_invalid, out_inexact, out_int}, {1'b1, exp});
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [33:0] prev;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 during reset", {out_valid, out_invalid, out_inexact, out_int}, 35'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_valid, out_invalid, out_inexact, out_int}, 35'd0);

        // R3: zero class ignores the other fields
        vec("R3 zero", 2'd0, 1'b1, 5, 40'hFF_FFFF_FFFF, 34'd0);
        // R4: infinity and NaN saturate
        vec("R4 +inf", 2'd2, 1'b0, 3, 40'h80_0000_0000, {2'b10, 32'h7FFF_FFFF});
        vec("R4 -nan", 2'd3, 1'b1, 0, 40'hC0_0000_0000, {2'b10, 32'h8000_0000});
        vec("R4 +nan", 2'd3, 1'b0, -4, 40'hC0_0000_0001, {2'b10, 32'h7FFF_FFFF});
        // R5: large exponents
        vec("R5 exp32", 2'd1, 1'b0, 32, 40'h80_0000_0000, {2'b10, 32'h7FFF_FFFF});
        vec("R5 exp40 neg", 2'd1, 1'b1, 40, 40'h80_0000_0000, {2'b10, 32'h8000_0000});
        // R6: exact 5.0
        vec("R6 five", 2'd1, 1'b0, 2, 40'hA0_0000_0000, {2'b00, 32'd5});
        // R7 and R10: +/-2.5 truncated toward zero
        vec("R7 +2.5", 2'd1, 1'b0, 1, 40'hA0_0000_0000, {2'b01, 32'd2});
        vec("R7 R10 -2.5", 2'd1, 1'b1, 1, 40'hA0_0000_0000, {2'b01, 32'hFFFF_FFFE});
        vec("R10 -5", 2'd1, 1'b1, 2, 40'hA0_0000_0000, {2'b00, 32'hFFFF_FFFB});
        // R8: 0.75 and -0.5
        vec("R8 0.75", 2'd1, 1'b0, -1, 40'hC0_0000_0000, {2'b01, 32'd0});
        vec("R8 -0.5", 2'd1, 1'b1, -1, 40'h80_0000_0000, {2'b01, 32'd0});
        // R9: boundary around 2^31
        vec("R9 -2^31", 2'd1, 1'b1, 31, 40'h80_0000_0000, {2'b00, 32'h8000_0000});
        vec("R9 +2^31", 2'd1, 1'b0, 31, 40'h80_0000_0000, {2'b10, 32'h7FFF_FFFF});
        vec("R9 -2^31-frac", 2'd1, 1'b1, 31, 40'h80_0000_0080, {2'b01, 32'h8000_0000});
        vec("R9 -2^31-1", 2'd1, 1'b1, 31, 40'h80_0000_0100, {2'b10, 32'h8000_0000});
        vec("R9 2^31-0.5", 2'd1, 1'b0, 30, 40'hFF_FFFF_FF00, {2'b01, 32'h7FFF_FFFF});
        // R11: shifts at and beyond the mantissa width
        vec("R11 exp-1 deep", 2'd1, 1'b0, -100, 40'h80_0000_0001, {2'b01, 32'd0});
        vec("R11 sh78", 2'd1, 1'b1, -39, 40'h80_0000_0000, {2'b01, 32'd0});
        vec("R11 zero mant", 2'd1, 1'b0, -60, 40'h00_0000_0000, {2'b00, 32'd0});

        // R2 and R12: idle cycle drains valid and holds data
        drive(2'd1, 1'b0, 10, 40'hC0_0000_0000);
        prev = {out_invalid, out_inexact, out_int};
        check("R2 valid after accept", {34'd0, out_valid}, 35'd1);
        @(negedge clk);
        check("R2 drain", {34'd0, out_valid}, 35'd0);
        check("R12 hold", {1'b0, out_invalid, out_inexact, out_int}, {1'b0, prev});

        // random phase
        for (int k = 0; k < 400; k++) begin
            logic [1:0]  c;
            logic        s;
            int          e;
            logic [39:0] m;
            logic [33:0] r;
            c = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'd1;
            s = 1'($urandom);
            e = int'($urandom % 90) - 45;
            m = {1'b1, 7'($urandom), 32'($urandom)};
            if ($urandom % 4 == 0) m[20:0] = '0;
            r = ref_conv(c, s, e, m);
            vec(r[33] ? "R5 R9 random overflow" : "R6 R7 R10 random", c, s, e, m, r);
            if (out_invalid && out_inexact) begin
                n_chk++;
                n_fail++;
                $display("FAIL R12 flags actual=11 expected=not both");
            end
            if ($urandom % 5 == 0) @(negedge clk);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule